// File: doc/BRIEF.md
# Viewport Outbound Address Translator

This block turns a CPU-side request address into a bus address using two programmable outbound windows. Software reaches every window register through a single viewport-select register: it first writes the direction and window index into the viewport, then writes or reads the shared set of window registers (type, enable, base, limit, target), which act on the selected window only.

The lookup side is purely combinational. A 64-bit request address is compared against every enabled outbound window. The lowest-numbered window that matches supplies the hit flag, its index, its transaction type and the translated address. Memory and I/O windows add the offset from the window base to a 64-bit target. Configuration windows carry a bus/device/function number in the target and keep only the low 12 bits of the offset as the register offset. Register writes land on the rising clock edge. Reads return the selected window's field in the same cycle.

Top module: `ovt_translator`

## Requirements
- R1: After reset the viewport selects outbound window 0, every window register reads 0, and no request address hits.
- R2: The viewport register (offset 0x900) stores the direction in bit 31 (1 inbound, 0 outbound) and the window index in its low bit. It reads back as written in those bits and reads 0 in all other bits.
- R3: The window registers are at type 0x904 (bits 4:0), enable 0x908 (bit 31), base low 0x90C, base high 0x910, limit 0x914, target low 0x918 and target high 0x91C. A write takes effect for the window selected by the viewport, and a read of the same offset returns the stored value.
- R4: A window hits when it is enabled, the request address is at least its 64-bit base, and the low 32 request address bits are at most its 32-bit limit. When nothing hits, hit, region, type and address outputs are all 0.
- R5: A window whose enable bit is clear never hits.
- R6: For a memory (type 0) or I/O (type 2) window, the translated address is the 64-bit target plus (request address - base), and the hit type equals the stored type.
- R7: For a configuration window (type 4 or 5), the translated address is {target high, target low bits 31:12, offset bits 11:0}, so the bus number (bits 31:24), device (23:19) and function (18:16) pass unchanged.
- R8: When several windows hit, the lowest-numbered window is reported.
- R9: Writes made while the viewport selects inbound are stored and read back, but leave outbound lookup unchanged.
- R10: Writes to offsets outside 0x900 to 0x91C are ignored, and reads of such offsets return 0.
- R11: A register write changes the lookup result starting from the clock edge on which it is captured, so reprogramming window 0 between accesses is seen at once afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_addr | input | 64 | Request address to translate |
| hit | output | 1 | Some outbound window matches |
| hit_region | output | 1 | Index of the matching window |
| hit_kind | output | 5 | Transaction type of the matching window |
| bus_addr | output | 64 | Translated bus address |

## Verification
The checks assume that reg_addr, reg_wr and req_addr are stable and known at each rising edge. They also assume that the limit is only programmed so that the window is meaningful under a 32-bit compare. The bench drives every input on the falling edge and samples a short delay later, so the combinational lookup settles before any edge. Window programming uses the same base/limit pairs that software would use, and one deliberate vector probes the upper-address alias caused by the 32-bit limit compare.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
    localparam int AW     = 64;
    localparam int DW     = 32;
    localparam int KW     = 5;
    localparam int RAW    = 12;
    localparam int CFG_OW = 12;

    localparam logic [RAW-1:0] OFS_VIEW    = 12'h900;
    localparam logic [RAW-1:0] OFS_KIND    = 12'h904;
    localparam logic [RAW-1:0] OFS_ENA     = 12'h908;
    localparam logic [RAW-1:0] OFS_BASE_LO = 12'h90C;
    localparam logic [RAW-1:0] OFS_BASE_HI = 12'h910;
    localparam logic [RAW-1:0] OFS_LIMIT   = 12'h914;
    localparam logic [RAW-1:0] OFS_TGT_LO  = 12'h918;
    localparam logic [RAW-1:0] OFS_TGT_HI  = 12'h91C;

    localparam logic [KW-1:0] KIND_CFG0 = 5'd4;
    localparam logic [KW-1:0] KIND_CFG1 = 5'd5;

    typedef struct packed {
        logic          en;
        logic [KW-1:0] kind;
        logic [DW-1:0] base_lo;
        logic [DW-1:0] base_hi;
        logic [DW-1:0] limit;
        logic [DW-1:0] tgt_lo;
        logic [DW-1:0] tgt_hi;
    } window_t;
endpackage

// File: rtl/ovt_regfile.sv
module ovt_regfile
    import ovt_pkg::*;
#(
    parameter int NREG = 2,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RAW-1:0]         addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    output window_t [NREG-1:0]     outb
);
    typedef struct packed {
        logic                         inb;
        logic [IW-1:0]                idx;
        window_t [1:0][NREG-1:0]      tbl;
    } state_t;

    state_t st_d, st_q;
    window_t sel;
    logic    sel_ok;

    always_comb begin
        sel_ok = (int'(st_q.idx) < NREG);
        sel    = sel_ok ? st_q.tbl[st_q.inb][st_q.idx] : '0;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == OFS_VIEW) begin
                st_d.inb = wdata[DW-1];
                st_d.idx = wdata[IW-1:0];
            end else if (sel_ok) begin
                case (addr)
                    OFS_KIND:    st_d.tbl[st_q.inb][st_q.idx].kind    = wdata[KW-1:0];
                    OFS_ENA:     st_d.tbl[st_q.inb][st_q.idx].en      = wdata[DW-1];
                    OFS_BASE_LO: st_d.tbl[st_q.inb][st_q.idx].base_lo = wdata;
                    OFS_BASE_HI: st_d.tbl[st_q.inb][st_q.idx].base_hi = wdata;
                    OFS_LIMIT:   st_d.tbl[st_q.inb][st_q.idx].limit   = wdata;
                    OFS_TGT_LO:  st_d.tbl[st_q.inb][st_q.idx].tgt_lo  = wdata;
                    OFS_TGT_HI:  st_d.tbl[st_q.inb][st_q.idx].tgt_hi  = wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            OFS_VIEW:    rdata = {st_q.inb, {(DW-1-IW){1'b0}}, st_q.idx};
            OFS_KIND:    rdata = {{(DW-KW){1'b0}}, sel.kind};
            OFS_ENA:     rdata = {sel.en, {(DW-1){1'b0}}};
            OFS_BASE_LO: rdata = sel.base_lo;
            OFS_BASE_HI: rdata = sel.base_hi;
            OFS_LIMIT:   rdata = sel.limit;
            OFS_TGT_LO:  rdata = sel.tgt_lo;
            OFS_TGT_HI:  rdata = sel.tgt_hi;
            default:     rdata = '0;
        endcase
    end

    assign outb = st_q.tbl[0];
endmodule

// File: rtl/ovt_window_match.sv
module ovt_window_match
    import ovt_pkg::*;
(
    input  window_t        win,
    input  logic [AW-1:0]  req_addr,
    output logic           match,
    output logic [AW-1:0]  xlat
);
    logic [AW-1:0] base;
    logic [AW-1:0] ofs;
    logic          is_cfg;

    always_comb begin
        base   = {win.base_hi, win.base_lo};
        ofs    = req_addr - base;
        is_cfg = (win.kind == KIND_CFG0) || (win.kind == KIND_CFG1);
        match  = win.en && (req_addr >= base) && (req_addr[DW-1:0] <= win.limit);
        if (is_cfg)
            xlat = {win.tgt_hi, win.tgt_lo[DW-1:CFG_OW], ofs[CFG_OW-1:0]};
        else
            xlat = {win.tgt_hi, win.tgt_lo} + ofs;
    end
endmodule

// File: rtl/ovt_translator.sv
module ovt_translator
    import ovt_pkg::*;
#(
    parameter int NREG = 2,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [AW-1:0]   req_addr,
    output logic            hit,
    output logic [IW-1:0]   hit_region,
    output logic [KW-1:0]   hit_kind,
    output logic [AW-1:0]   bus_addr
);
    window_t [NREG-1:0]         outb;
    logic    [NREG-1:0]         match;
    logic    [NREG-1:0][AW-1:0] xlat;

    ovt_regfile #(.NREG(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .outb  (outb)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_win
        ovt_window_match u_match (
            .win      (outb[r]),
            .req_addr (req_addr),
            .match    (match[r]),
            .xlat     (xlat[r])
        );
    end

    always_comb begin
        hit        = 1'b0;
        hit_region = '0;
        hit_kind   = '0;
        bus_addr   = '0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (match[r]) begin
                hit        = 1'b1;
                hit_region = IW'(r);
                hit_kind   = outb[r].kind;
                bus_addr   = xlat[r];
            end
        end
    end
endmodule

// File: rtl/ovt_checker.sv
module ovt_checker
    import ovt_pkg::*;
#(
    parameter int NREG = 2,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [RAW-1:0]     reg_addr,
    input logic               vp_inbound,
    input window_t [NREG-1:0] outb,
    input logic [NREG-1:0]    match,
    input logic [AW-1:0]      req_addr,
    input logic               hit,
    input logic [IW-1:0]      hit_region,
    input logic [AW-1:0]      bus_addr
);
    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> outb[hit_region].en); // R5

    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req_addr >= {outb[hit_region].base_hi, outb[hit_region].base_lo})
             && (req_addr[DW-1:0] <= outb[hit_region].limit)); // R4

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_addr == '0)); // R4

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match & ~({NREG{1'b1}} << hit_region)) == '0)); // R8

    AST_INBOUND_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && vp_inbound && reg_addr != OFS_VIEW) |=> $stable(outb)); // R9
endmodule

bind ovt_translator ovt_checker #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .vp_inbound (u_regs.st_q.inb),
    .outb       (outb),
    .match      (match),
    .req_addr   (req_addr),
    .hit        (hit),
    .hit_region (hit_region),
    .bus_addr   (bus_addr)
);

// File: tb/ovt_translator_test.sv
`timescale 1ns/1ps
module ovt_translator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] req_addr = '0;
    logic        hit;
    logic [0:0]  hit_region;
    logic [4:0]  hit_kind;
    logic [63:0] bus_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ovt_translator uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
        .hit(hit), .hit_region(hit_region), .hit_kind(hit_kind), .bus_addr(bus_addr)
    );

    // addr[134:71] hit[70] region[69] kind[68:64] out[63:0]
    localparam int NV = 12;
    localparam logic [134:0] VEC [NV] = '{
        {64'h0000_0001_2000_0000, 1'b1, 1'b0, 5'd4, 64'h0000_0000_032A_0000},
        {64'h0000_0001_2000_0ABC, 1'b1, 1'b0, 5'd4, 64'h0000_0000_032A_0ABC},
        {64'h0000_0001_2000_1234, 1'b1, 1'b0, 5'd4, 64'h0000_0000_032A_0234},
        {64'h0000_0001_2000_FFFF, 1'b1, 1'b0, 5'd4, 64'h0000_0000_032A_0FFF},
        {64'h0000_0001_2001_0000, 1'b0, 1'b0, 5'd0, 64'h0},
        {64'h0000_0001_1FFF_FFFF, 1'b0, 1'b0, 5'd0, 64'h0},
        {64'h0000_0001_4000_0000, 1'b1, 1'b1, 5'd0, 64'h0000_0000_9000_0000},
        {64'h0000_0001_4123_4568, 1'b1, 1'b1, 5'd0, 64'h0000_0000_9123_4568},
        {64'h0000_0001_4FFF_FFFF, 1'b1, 1'b1, 5'd0, 64'h0000_0000_9FFF_FFFF},
        {64'h0000_0001_5000_0000, 1'b0, 1'b0, 5'd0, 64'h0},
        {64'h0000_0000_4000_0000, 1'b0, 1'b0, 5'd0, 64'h0},
        {64'h0000_0002_4000_0010, 1'b1, 1'b1, 5'd0, 64'h0000_0001_9000_0010}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic look(input logic [63:0] a, input string tag, input logic h,
                        input logic r, input logic [4:0] k, input logic [63:0] o);
        req_addr = a;
        #1;
        check({tag, " hit"},    {63'b0, hit}, {63'b0, h});
        check({tag, " region"}, {63'b0, hit_region}, {63'b0, r});
        check({tag, " kind"},   {59'b0, hit_kind}, {59'b0, k});
        check({tag, " addr"},   bus_addr, o);
    endtask

    task automatic prog(input logic idx, input logic [4:0] k, input logic [63:0] base,
                        input logic [31:0] lim, input logic [63:0] tgt, input logic en);
        wr(12'h900, {31'b0, idx});
        wr(12'h90C, base[31:0]);
        wr(12'h910, base[63:32]);
        wr(12'h914, lim);
        wr(12'h918, tgt[31:0]);
        wr(12'h91C, tgt[63:32]);
        wr(12'h904, {27'b0, k});
        wr(12'h908, {en, 31'b0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        // R1: reset state, still in reset
        rd(12'h900, d); check("R1 viewport in reset", {32'b0, d}, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(12'h908, d); check("R1 enable after reset", {32'b0, d}, 64'h0);
        rd(12'h914, d); check("R1 limit after reset", {32'b0, d}, 64'h0);
        look(64'h0, "R1 no hit", 1'b0, 1'b0, 5'd0, 64'h0);

        // program: window 0 config type 0 (bus 3 dev 5 fn 2), window 1 memory
        prog(1'b0, 5'd4, 64'h1_2000_0000, 32'h2000_FFFF, 64'h0000_0000_032A_0000, 1'b1);
        prog(1'b1, 5'd0, 64'h1_4000_0000, 32'h4FFF_FFFF, 64'h0000_0000_9000_0000, 1'b1);

        // R4 R6 R7 table walk
        for (int i = 0; i < NV; i++) begin
            look(VEC[i][134:71], $sformatf("R4/R6/R7 vec%0d", i),
                 VEC[i][70], VEC[i][69], VEC[i][68:64], VEC[i][63:0]);
        end

        // R2 viewport readback
        wr(12'h900, 32'h8000_0001);
        rd(12'h900, d); check("R2 viewport readback", {32'b0, d}, 64'h8000_0001);
        wr(12'h900, 32'h0000_0001);
        rd(12'h900, d); check("R2 viewport outbound", {32'b0, d}, 64'h1);

        // R3 readback of window 1
        rd(12'h90C, d); check("R3 base lo w1", {32'b0, d}, 64'h4000_0000);
        rd(12'h910, d); check("R3 base hi w1", {32'b0, d}, 64'h1);
        rd(12'h91C, d); check("R3 tgt hi w1", {32'b0, d}, 64'h0);
        wr(12'h900, 32'h0);
        rd(12'h904, d); check("R3 kind w0", {32'b0, d}, 64'h4);
        rd(12'h918, d); check("R3 tgt lo w0", {32'b0, d}, 64'h032A_0000);

        // R9 inbound writes do not touch lookup
        wr(12'h900, 32'h8000_0000);
        wr(12'h904, 32'h2);
        wr(12'h908, 32'h8000_0000);
        wr(12'h90C, 32'h7000_0000);
        rd(12'h904, d); check("R9 inbound kind readback", {32'b0, d}, 64'h2);
        rd(12'h908, d); check("R9 inbound enable readback", {32'b0, d}, 64'h8000_0000);
        look(64'h1_2000_1234, "R9 outbound w0 unchanged", 1'b1, 1'b0, 5'd4, 64'h032A_0234);
        look(64'h0_7000_0000, "R9 inbound window inert", 1'b0, 1'b0, 5'd0, 64'h0);
        wr(12'h900, 32'h0);
        rd(12'h904, d); check("R9 outbound kind kept", {32'b0, d}, 64'h4);

        // R10 unmapped offset
        wr(12'h920, 32'hFFFF_FFFF);
        rd(12'h920, d); check("R10 unmapped read", {32'b0, d}, 64'h0);
        look(64'h1_4000_0000, "R10 lookup unchanged", 1'b1, 1'b1, 5'd0, 64'h9000_0000);

        // R6 I/O type on window 0 (viewport at window 0)
        wr(12'h904, 32'h2);
        look(64'h1_2000_1234, "R6 io type", 1'b1, 1'b0, 5'd2, 64'h032A_1234);
        wr(12'h904, 32'h5);
        look(64'h1_2000_1234, "R7 cfg type 1", 1'b1, 1'b0, 5'd5, 64'h032A_0234);

        // R8 overlap: window 1 over window 0
        prog(1'b1, 5'd0, 64'h1_2000_0000, 32'h2000_FFFF, 64'h0, 1'b1);
        look(64'h1_2000_0010, "R8 lowest wins", 1'b1, 1'b0, 5'd5, 64'h032A_0010);

        // R5 disable window 0
        wr(12'h900, 32'h0);
        wr(12'h908, 32'h0);
        look(64'h1_2000_0010, "R5 disabled w0 skipped", 1'b1, 1'b1, 5'd0, 64'h10);
        wr(12'h900, 32'h1);
        wr(12'h908, 32'h0);
        look(64'h1_2000_0010, "R5 both disabled", 1'b0, 1'b0, 5'd0, 64'h0);

        // R11 write seen right after its capture edge
        wr(12'h900, 32'h0);
        req_addr = 64'h1_2000_0020;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h908; reg_wdata = 32'h8000_0000;
        #1;
        check("R11 before edge", {63'b0, hit}, 64'h0);
        @(posedge clk); #1;
        check("R11 after edge", {63'b0, hit}, 64'h1);
        check("R11 addr after edge", bus_addr, 64'h032A_0020);
        @(negedge clk); reg_wr = 1'b0;

        // R1 reset clears programmed state
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(64'h1_2000_0020, "R1 reset clears", 1'b0, 1'b0, 5'd0, 64'h0);

        finish_run();
    end
endmodule